// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Controller

This block watches one external non-maskable interrupt line and raises one interrupt request toward an upstream interrupt controller. The asynchronous line first goes through a synchroniser. It is then judged against a trigger type that software selects: an active-low level, an active-high level, a falling edge or a rising edge. A qualifying condition sets a sticky pending flag. Software clears that flag by writing a one to it. An enable flag gates the pending flag onto the registered request output.

Software reaches three registers through a simple single-cycle register bus:

- **Type/control word**: holds the trigger type and general storage.
- **Pending word**: holds the pending flag.
- **Enable word**: holds the enable flag.

The elaboration parameter `LAYOUT` places these three words at one of three address maps. In edge modes, software acknowledges the pending flag before it services the event. In level modes, software clears the flag when service ends, and the flag sets again while the line stays asserted.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the type/control word, pending word and enable word all read 0, and `irq_o` is 0. The type field value 0 then means active-low level. The line synchroniser resets to the high (idle) state.
- R2: The type/control word is full-width read/write storage. Bits [1:0] hold the trigger type. A write that changes only the type field keeps every other bit that was written.
- R3: With type 0, the pending flag (pending word bit 0) sets on every cycle the synchronised line is low. With type 2, it sets on every cycle the synchronised line is high.
- R4: With type 3, pending sets once on a low-to-high transition of the synchronised line. With type 1, it sets once on a high-to-low transition. A steady line, or a transition in the other direction, sets nothing.
- R5: Writing a word with bit 0 = 1 to the pending address clears the pending flag. Writing bit 0 = 0 leaves the flag unchanged.
- R6: When a set condition and a clearing write fall in the same cycle, pending ends that cycle at 1. So clearing in a level mode while the line is still asserted leaves pending at 1.
- R7: `irq_o` is registered and equals (pending AND enable) as it stood one clock earlier. Enable is bit 0 of the enable word, and writing 0 there disables the request.
- R8: A change on `nmi_i` reaches the pending flag on the third rising clock edge after the change: two synchroniser flops, then the pending flop.
- R9: Register offsets depend on `LAYOUT`:
  - Layout 0: type/control at 0x00, pending at 0x04, enable at 0x08.
  - Layout 1: type/control at 0x00, enable at 0x04, pending at 0x08.
  - Layout 2: type/control at 0x0C, pending at 0x10, enable at 0x40.
- R10: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R11: In the pending and enable words, only bit 0 is stored. All higher bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Asynchronous external interrupt line |
| bus_sel_i | input | 1 | Bus access strobe for this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational, 0 when not reading |
| irq_o | output | 1 | Registered interrupt request to the upstream controller |

## Verification
The assertions assume that bus accesses are single-cycle strobes whose address and data are steady around the sampling edge. They also assume that `nmi_i` needs no metastability model: a change is taken as seen at the first synchroniser flop on the next edge.

The bench drives the line and every bus field only at falling clock edges, so each value is clean at the rising edge that captures it. It holds the line steady for at least four cycles between transitions, except in the one scenario that deliberately lines up a set with a clear.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

    // Trigger type encoding held in the type/control field
    typedef enum logic [1:0] {
        TRIG_LEVEL_LOW  = 2'd0,
        TRIG_FALL_EDGE  = 2'd1,
        TRIG_LEVEL_HIGH = 2'd2,
        TRIG_RISE_EDGE  = 2'd3
    } trig_e;

    function automatic logic [7:0] ctrl_off(input int layout);
        return (layout == 2) ? 8'h0C : 8'h00;
    endfunction

    function automatic logic [7:0] pend_off(input int layout);
        case (layout)
            1:       return 8'h08;
            2:       return 8'h10;
            default: return 8'h04;
        endcase
    endfunction

    function automatic logic [7:0] en_off(input int layout);
        case (layout)
            1:       return 8'h04;
            2:       return 8'h40;
            default: return 8'h08;
        endcase
    endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o,
    output logic prev_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

    // Edge detection in R4 needs prev to be last cycle's synchronised sample
    assert_prev_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> prev_o == $past(sync_o));

endmodule

// File: rtl/nmi_trigger_detect.sv
module nmi_trigger_detect
    import nmi_pkg::*;
(
    input  trig_e mode_i,
    input  logic  cur_i,
    input  logic  prev_i,
    output logic  set_o
);
    always_comb begin
        case (mode_i)
            TRIG_LEVEL_LOW:  set_o = !cur_i;
            TRIG_FALL_EDGE:  set_o = prev_i && !cur_i;
            TRIG_LEVEL_HIGH: set_o = cur_i;
            TRIG_RISE_EDGE:  set_o = !prev_i && cur_i;
            default:         set_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nmi_addr_decode.sv
module nmi_addr_decode #(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 8
) (
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_ctrl_o,
    output logic              hit_pend_o,
    output logic              hit_en_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(nmi_pkg::ctrl_off(LAYOUT));
    localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(nmi_pkg::pend_off(LAYOUT));
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(nmi_pkg::en_off(LAYOUT));

    always_comb begin
        hit_ctrl_o = sel_i && (addr_i == CTRL_A);
        hit_pend_o = sel_i && (addr_i == PEND_A);
        hit_en_o   = sel_i && (addr_i == EN_A);
    end
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
    import nmi_pkg::*;
#(
    parameter int LAYOUT      = 0,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int TYPE_W = 2;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              pend;
        logic              en;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;

    logic line_cur, line_prev, set_hit;
    logic hit_ctrl, hit_pend, hit_en;
    logic wr_ctrl, wr_pend, wr_en, clr_req;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(nmi_i),
        .sync_o (line_cur),
        .prev_o (line_prev)
    );

    nmi_trigger_detect u_detect (
        .mode_i(trig_e'(r_q.ctrl[TYPE_W-1:0])),
        .cur_i (line_cur),
        .prev_i(line_prev),
        .set_o (set_hit)
    );

    nmi_addr_decode #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) u_decode (
        .sel_i     (bus_sel_i),
        .addr_i    (bus_addr_i),
        .hit_ctrl_o(hit_ctrl),
        .hit_pend_o(hit_pend),
        .hit_en_o  (hit_en)
    );

    assign wr_ctrl = hit_ctrl && bus_wr_i;
    assign wr_pend = hit_pend && bus_wr_i;
    assign wr_en   = hit_en   && bus_wr_i;
    assign clr_req = wr_pend && bus_wdata_i[0];

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.ctrl = bus_wdata_i;
        if (wr_en)   r_d.en   = bus_wdata_i[0];
        // set has priority over a simultaneous clear
        r_d.pend = set_hit || (r_q.pend && !clr_req);
        r_d.irq  = r_q.pend && r_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            if (hit_ctrl)      bus_rdata_o = r_q.ctrl;
            else if (hit_pend) bus_rdata_o = DATA_W'(r_q.pend);
            else if (hit_en)   bus_rdata_o = DATA_W'(r_q.en);
        end
    end

    assign irq_o = r_q.irq;

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> r_q.pend);

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_hit) |=> !r_q.pend);

    assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !set_hit) |=> $stable(r_q.pend));

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> !irq_o);

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(r_q.pend));

endmodule

// File: tb/nmi_line_ctrl_bench.sv
module nmi_line_ctrl_bench;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi = 1'b1;
    logic wr = 1'b0;
    logic [2:0] sel = 3'b000;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd0, rd1, rd2;
    logic irq0, irq1, irq2;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nmi_line_ctrl #(.LAYOUT(0)) u_nmi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .bus_sel_i(sel[0]), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd0), .irq_o(irq0));

    nmi_line_ctrl #(.LAYOUT(1)) u_nmi_line_ctrl_l1 (
        .clk(clk), .rst_n(rst_n), .nmi_i(1'b1), .bus_sel_i(sel[1]), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd1), .irq_o(irq1));

    nmi_line_ctrl #(.LAYOUT(2)) u_nmi_line_ctrl_l2 (
        .clk(clk), .rst_n(rst_n), .nmi_i(1'b1), .bus_sel_i(sel[2]), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rd2), .irq_o(irq2));

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input int inst, input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel = 3'b000;
        sel[inst] = 1'b1;
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 3'b000; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input int inst, input logic [AW-1:0] a, output logic [DW-1:0] d);
        sel = 3'b000;
        sel[inst] = 1'b1;
        wr = 1'b0; addr = a;
        #1;
        d = (inst == 0) ? rd0 : (inst == 1) ? rd1 : rd2;
        sel = 3'b000;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        bus_rd(0, 8'h00, v); chk("R1 ctrl", v, 0);
        bus_rd(0, 8'h04, v); chk("R1 pend", v, 0);
        bus_rd(0, 8'h08, v); chk("R1 en", v, 0);
        chk("R1 irq", {31'd0, irq0}, 0);
    endtask

    task automatic t_ctrl_rw;
        logic [DW-1:0] v;
        bus_wr(0, 8'h00, 32'hA5A5_5A01);
        bus_rd(0, 8'h00, v); chk("R2 ctrl readback", v, 32'hA5A5_5A01);
        bus_wr(0, 8'h00, (v & ~32'h3) | 32'h2);
        bus_rd(0, 8'h00, v); chk("R2 type rmw keeps upper bits", v, 32'hA5A5_5A02);
        bus_wr(0, 8'h00, 32'h0);
    endtask

    task automatic t_level_high;
        logic [DW-1:0] v;
        nmi = 1'b0; tick(4);
        bus_wr(0, 8'h00, 32'h2);
        bus_wr(0, 8'h04, 32'h1);
        bus_rd(0, 8'h04, v); chk("R5 clear before level-high test", v, 0);
        nmi = 1'b1;
        tick(2);
        bus_rd(0, 8'h04, v); chk("R8 not yet pending after two edges", v, 0);
        tick(1);
        bus_rd(0, 8'h04, v); chk("R8 R3 pending on third edge", v, 1);
        tick(1);
        chk("R7 irq blocked while disabled", {31'd0, irq0}, 0);
        bus_wr(0, 8'h08, 32'h1);
        chk("R7 irq registered, not yet high", {31'd0, irq0}, 0);
        tick(1);
        chk("R7 irq high one edge after enable", {31'd0, irq0}, 1);
        bus_wr(0, 8'h04, 32'h1);
        bus_rd(0, 8'h04, v); chk("R6 level still high re-sets pending", v, 1);
        nmi = 1'b0; tick(3);
        bus_wr(0, 8'h04, 32'h1);
        bus_rd(0, 8'h04, v); chk("R5 clear after level drops", v, 0);
        chk("R7 irq still high from previous state", {31'd0, irq0}, 1);
        tick(1);
        chk("R7 irq drops after clear", {31'd0, irq0}, 0);
        bus_wr(0, 8'h08, 32'h0);
    endtask

    task automatic t_level_low;
        logic [DW-1:0] v;
        bus_wr(0, 8'h00, 32'h0);
        tick(3);
        bus_rd(0, 8'h04, v); chk("R3 level-low sets pending", v, 1);
        bus_wr(0, 8'h04, 32'hFFFF_FFFE);
        bus_rd(0, 8'h04, v); chk("R5 writing 0 leaves pending", v, 1);
        nmi = 1'b1; tick(3);
        bus_wr(0, 8'h04, 32'h1);
        tick(2);
        bus_rd(0, 8'h04, v); chk("R3 level-low idle stays clear", v, 0);
    endtask

    task automatic t_rising;
        logic [DW-1:0] v;
        bus_wr(0, 8'h00, 32'h3);
        bus_wr(0, 8'h04, 32'h1);
        nmi = 1'b0; tick(4);
        bus_rd(0, 8'h04, v); chk("R4 falling ignored in rising mode", v, 0);
        nmi = 1'b1; tick(4);
        bus_rd(0, 8'h04, v); chk("R4 rising edge sets pending", v, 1);
        bus_wr(0, 8'h04, 32'h1);
        tick(3);
        bus_rd(0, 8'h04, v); chk("R4 steady high sets only once", v, 0);
    endtask

    task automatic t_falling;
        logic [DW-1:0] v;
        bus_wr(0, 8'h00, 32'h1);
        bus_wr(0, 8'h04, 32'h1);
        nmi = 1'b0; tick(4);
        bus_rd(0, 8'h04, v); chk("R4 falling edge sets pending", v, 1);
        bus_wr(0, 8'h04, 32'h1);
        tick(3);
        bus_rd(0, 8'h04, v); chk("R4 steady low sets only once", v, 0);
        nmi = 1'b1; tick(4);
        bus_rd(0, 8'h04, v); chk("R4 rising ignored in falling mode", v, 0);
    endtask

    task automatic t_set_wins;
        logic [DW-1:0] v;
        bus_wr(0, 8'h00, 32'h3);
        nmi = 1'b0; tick(4);
        bus_wr(0, 8'h04, 32'h1);
        nmi = 1'b1;
        tick(2);
        bus_wr(0, 8'h04, 32'h1);
        bus_rd(0, 8'h04, v); chk("R6 edge set beats same-cycle clear", v, 1);
        bus_wr(0, 8'h04, 32'h1);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] v;
        bus_wr(0, 8'h00, 32'h0000_1230);
        bus_wr(0, 8'h20, 32'hFFFF_FFFF);
        bus_rd(0, 8'h20, v); chk("R10 unmapped read zero", v, 0);
        bus_rd(0, 8'h00, v); chk("R10 unmapped write left ctrl", v, 32'h0000_1230);
        bus_rd(0, 8'h08, v); chk("R10 unmapped write left enable", v, 0);
        bus_wr(0, 8'h08, 32'hFFFF_FFFF);
        bus_rd(0, 8'h08, v); chk("R11 enable upper bits read zero", v, 1);
        bus_wr(0, 8'h08, 32'h0);
        bus_wr(0, 8'h00, 32'h0);
        tick(3);
        bus_rd(0, 8'h04, v); chk("R11 pending upper bits read zero", v, 0);
    endtask

    task automatic t_layouts;
        logic [DW-1:0] v;
        bus_wr(1, 8'h00, 32'h3C);
        bus_rd(1, 8'h00, v); chk("R9 layout1 ctrl at 0x00", v, 32'h3C);
        bus_wr(1, 8'h04, 32'h1);
        bus_rd(1, 8'h04, v); chk("R9 layout1 enable at 0x04", v, 1);
        bus_rd(1, 8'h08, v); chk("R9 layout1 pending at 0x08", v, 0);
        bus_wr(2, 8'h0C, 32'h55);
        bus_rd(2, 8'h0C, v); chk("R9 layout2 ctrl at 0x0C", v, 32'h55);
        bus_wr(2, 8'h40, 32'h1);
        bus_rd(2, 8'h40, v); chk("R9 layout2 enable at 0x40", v, 1);
        bus_rd(2, 8'h00, v); chk("R9 R10 layout2 0x00 unmapped", v, 0);
        bus_rd(2, 8'h10, v); chk("R9 layout2 pending at 0x10", v, 0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_ctrl_rw();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_set_wins();
        t_unmapped();
        t_layouts();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule